// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Line Ownership

This block controls a set of general-purpose I/O lines (32 by default) through two register banks. One is a common bank that is always reachable. The other is a secure bank that answers only while the `priv_ok` input is high. A per-line select register, held in the secure bank, picks the bank that drives each line. Where a select bit is 1, the line follows the common bank's output and direction registers. Where it is 0, the line follows the secure bank. Writes to the bank that does not own a line are still stored, but they have no effect on the pin. A secure line-enable register must also be set before any line can drive.

Each line has a level-sensitive interrupt detector. The pin is first brought into the clock domain by a two-flop synchroniser. The detector then compares the synchronised level with a programmable polarity bit. When they match, it sets a sticky flag in the bank that owns the line. Software clears a flag by writing 1 to its bit. If the level still matches, the flag sets again one clock later. A single interrupt output is raised while any flag of the common bank is set and also enabled in that bank's mask.

The bus side is a plain word-addressed register port. Reads are combinational from the address. A write takes effect on the clock edge where `bus_we` is high. There is no state machine. A fixed address decoder feeds two identical bank instances.

Top module: `gpio_dual_bank`

Register map, by word-aligned byte offset (all registers NLINES bits wide, one bit per line):

| Offset | Name | Bank | Access |
|---|---|---|---|
| 0x00 | DOUT | common | read/write |
| 0x04 | DDIR | common | read/write |
| 0x08 | DIN | common | read-only |
| 0x0C | POL | common | read/write |
| 0x10 | PEND | common | write 1 to clear |
| 0x14 | IEN | common | read/write |
| 0x18 | DIN_ALT | common | read-only |
| 0x1C | LINE_EN | secure | read/write |
| 0x20 | DOUT | secure | read/write |
| 0x24 | DDIR | secure | read/write |
| 0x28 | DIN | secure | read-only |
| 0x2C | POL | secure | read/write |
| 0x30 | PEND | secure | write 1 to clear |
| 0x34 | IEN | secure | read/write |
| 0x38 | DIN_ALT | secure | read-only |
| 0x3C | SEL | secure | read/write |

## Requirements
- R1: While `rst_n` is low, every register at offsets 0x00 to 0x3C reads 0, `pin_oe` is 0, `pin_out` is 0 and `irq_out` is 0.
- R2: The register map is the one given above. `bus_rdata` follows `bus_addr` combinationally. An address with bits [1:0] not equal to 0 selects no register and reads 0.
- R3: The common bank (0x00 to 0x18) is always accessible. While `priv_ok` is 0, offsets 0x1C to 0x3C read 0 and writes to them are ignored. This includes SEL (0x3C) and LINE_EN (0x1C).
- R4: `pin_out[i]` equals common DOUT[i] when SEL[i] is 1 and secure DOUT[i] when SEL[i] is 0. Both banks' DOUT and DDIR keep and read back what was written, whether or not the bank owns the line.
- R5: `pin_oe[i]` equals the owning bank's DDIR[i] ANDed with LINE_EN[i]. A DDIR bit of 1 means the line drives.
- R6: DIN and DIN_ALT of both banks return the pin level after two clock edges of synchronisation, whatever the owner. Writes to them are ignored.
- R7: A flag bit of a bank is set by the clock edge that follows a cycle in which the bank owns the line and the synchronised level equals the bank's POL bit. POL 1 selects active-high and POL 0 selects active-low. For a pin change before edge k, the flag is set at edge k+2.
- R8: Writing 1 to a PEND bit clears that flag at that edge, and clearing takes priority over a simultaneous set. A flag whose condition has ended stays set until it is cleared. A flag whose condition persists sets again at the next edge.
- R9: `irq_out` is high exactly when (common PEND & common IEN) is non-zero. Secure flags never raise it, and a common IEN of 0 holds it low.
- R10: A bank never sets flags for lines it does not own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_ok | input | 1 | Permits access to the secure bank |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| pin_in | input | NLINES | Pad input levels |
| pin_out | output | NLINES | Pad output levels |
| pin_oe | output | NLINES | Pad output enables |
| irq_out | output | 1 | Combined interrupt from the common bank |

## Verification
- A register write is visible on `bus_rdata`, `pin_out` and `pin_oe` right after its edge, so the bench samples them on the following falling edge.
- A pin change made on a falling edge reaches DIN after the second rising edge. It reaches the flags and `irq_out` after the third, so the bench checks the old value, the old value again, and then the new one on successive falling edges.
- The bench expects a cleared flag to read 0 before the next edge and to be set again one edge later. Before it computes expected flags from owner, polarity and pin level, it always waits at least three edges after any change in those inputs.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;

    localparam int GPIO_ADDR_W = 6;
    localparam int GPIO_IDX_W  = 4;
    localparam int GPIO_COMMON_WORDS = 7;

    localparam logic [GPIO_ADDR_W-1:0] OFS_LINE_EN = 6'h1C;
    localparam logic [GPIO_ADDR_W-1:0] OFS_SEL     = 6'h3C;

    // Register kind inside a bank; the value equals the word index within the bank.
    typedef enum logic [2:0] {
        RK_DOUT = 3'd0,
        RK_DDIR = 3'd1,
        RK_DIN  = 3'd2,
        RK_POL  = 3'd3,
        RK_PEND = 3'd4,
        RK_IEN  = 3'd5,
        RK_MIRR = 3'd6,
        RK_NONE = 3'd7
    } reg_kind_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_COMMON,
        TGT_SECURE,
        TGT_LINE_EN,
        TGT_SEL
    } target_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [STAGES-1:0][N-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_dual_pkg::*;
(
    input  logic [GPIO_ADDR_W-1:0] addr,
    input  logic                   priv_ok,
    output target_e                target,
    output reg_kind_e              kind,
    output logic                   permit
);
    logic [GPIO_IDX_W-1:0] idx;
    assign idx = addr[GPIO_ADDR_W-1:2];

    always_comb begin
        target = TGT_NONE;
        kind   = RK_NONE;
        if (addr[1:0] == 2'b00) begin
            unique case (idx[3])
                1'b0: begin
                    if (idx[2:0] == 3'd7) begin
                        target = TGT_LINE_EN;
                    end else begin
                        target = TGT_COMMON;
                        kind   = reg_kind_e'(idx[2:0]);
                    end
                end
                1'b1: begin
                    if (idx[2:0] == 3'd7) begin
                        target = TGT_SEL;
                    end else begin
                        target = TGT_SECURE;
                        kind   = reg_kind_e'(idx[2:0]);
                    end
                end
                default: target = TGT_NONE;
            endcase
        end
    end

    assign permit = (target == TGT_COMMON) || priv_ok;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_dual_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  reg_kind_e    wr_kind,
    input  logic [N-1:0] wr_data,
    input  logic [N-1:0] owned,
    input  logic [N-1:0] pin_sync,
    output logic [N-1:0] r_dout,
    output logic [N-1:0] r_ddir,
    output logic [N-1:0] r_pol,
    output logic [N-1:0] r_pend,
    output logic [N-1:0] r_ien
);
    logic [N-1:0] hit;
    logic [N-1:0] clr;

    assign hit = owned & ~(pin_sync ^ r_pol);
    assign clr = (wr_stb && wr_kind == RK_PEND) ? wr_data : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_dout <= '0;
            r_ddir <= '0;
            r_pol  <= '0;
            r_pend <= '0;
            r_ien  <= '0;
        end else begin
            if (wr_stb) begin
                case (wr_kind)
                    RK_DOUT: r_dout <= wr_data;
                    RK_DDIR: r_ddir <= wr_data;
                    RK_POL:  r_pol  <= wr_data;
                    RK_IEN:  r_ien  <= wr_data;
                    default: ;
                endcase
            end
            r_pend <= (r_pend | hit) & ~clr;
        end
    end

    // R7 R10
    flag_set_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_pend & ~$past(r_pend)) & ~$past(hit)) == '0);

    // R8
    flag_clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_kind == RK_PEND) |=> ((r_pend & $past(wr_data)) == '0));

endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
    import gpio_dual_pkg::*;
#(
    parameter int NLINES      = 32,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   priv_ok,
    input  logic                   bus_we,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [NLINES-1:0]      pin_in,
    output logic [NLINES-1:0]      pin_out,
    output logic [NLINES-1:0]      pin_oe,
    output logic                   irq_out
);
    typedef logic [NLINES-1:0] lines_t;

    target_e   target;
    reg_kind_e kind;
    logic      permit;
    logic      wr_ok;
    lines_t    wr_lines;
    lines_t    pin_sync;
    lines_t    r_sel, r_line_en;
    lines_t    c_dout, c_ddir, c_pol, c_pend, c_ien;
    lines_t    s_dout, s_ddir, s_pol, s_pend, s_ien;
    lines_t    rd_lines;

    assign wr_lines = lines_t'(bus_wdata);
    assign wr_ok    = bus_we && permit;

    gpio_addr_dec u_dec (
        .addr    (bus_addr),
        .priv_ok (priv_ok),
        .target  (target),
        .kind    (kind),
        .permit  (permit)
    );

    gpio_sync #(.N(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_bank #(.N(NLINES)) u_common (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_ok && target == TGT_COMMON),
        .wr_kind  (kind),
        .wr_data  (wr_lines),
        .owned    (r_sel),
        .pin_sync (pin_sync),
        .r_dout   (c_dout),
        .r_ddir   (c_ddir),
        .r_pol    (c_pol),
        .r_pend   (c_pend),
        .r_ien    (c_ien)
    );

    gpio_bank #(.N(NLINES)) u_secure (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_ok && target == TGT_SECURE),
        .wr_kind  (kind),
        .wr_data  (wr_lines),
        .owned    (~r_sel),
        .pin_sync (pin_sync),
        .r_dout   (s_dout),
        .r_ddir   (s_ddir),
        .r_pol    (s_pol),
        .r_pend   (s_pend),
        .r_ien    (s_ien)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_sel     <= '0;
            r_line_en <= '0;
        end else if (wr_ok) begin
            if (target == TGT_SEL)     r_sel     <= wr_lines;
            if (target == TGT_LINE_EN) r_line_en <= wr_lines;
        end
    end

    function automatic lines_t bank_view(input reg_kind_e k, input lines_t dout,
                                         input lines_t ddir, input lines_t pol,
                                         input lines_t pend, input lines_t ien,
                                         input lines_t din);
        case (k)
            RK_DOUT: return dout;
            RK_DDIR: return ddir;
            RK_DIN:  return din;
            RK_POL:  return pol;
            RK_PEND: return pend;
            RK_IEN:  return ien;
            RK_MIRR: return din;
            default: return '0;
        endcase
    endfunction

    always_comb begin
        rd_lines = '0;
        if (permit) begin
            unique case (target)
                TGT_COMMON:  rd_lines = bank_view(kind, c_dout, c_ddir, c_pol, c_pend, c_ien, pin_sync);
                TGT_SECURE:  rd_lines = bank_view(kind, s_dout, s_ddir, s_pol, s_pend, s_ien, pin_sync);
                TGT_LINE_EN: rd_lines = r_line_en;
                TGT_SEL:     rd_lines = r_sel;
                default:     rd_lines = '0;
            endcase
        end
    end

    assign bus_rdata = DATA_W'(rd_lines);

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        assign pin_out[g] = r_sel[g] ? c_dout[g] : s_dout[g];
        assign pin_oe[g]  = (r_sel[g] ? c_ddir[g] : s_ddir[g]) & r_line_en[g];
    end

    assign irq_out = |(c_pend & c_ien);

    // R9
    irq_quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ien == '0) |-> !irq_out);

    // R3
    sel_denied_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !priv_ok && bus_addr == OFS_SEL) |=> $stable(r_sel));

    // R3
    line_en_denied_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !priv_ok && bus_addr == OFS_LINE_EN) |=> $stable(r_line_en));

endmodule

// File: tb/sim_gpio_dual_bank.sv
`timescale 1ns/1ps
module sim_gpio_dual_bank;

    localparam logic [5:0] A_DOUT_C = 6'h00, A_DDIR_C = 6'h04, A_DIN_C = 6'h08,
                           A_POL_C  = 6'h0C, A_PEND_C = 6'h10, A_IEN_C = 6'h14,
                           A_MIRR_C = 6'h18, A_EN     = 6'h1C, A_DOUT_S = 6'h20,
                           A_DDIR_S = 6'h24, A_DIN_S  = 6'h28, A_POL_S  = 6'h2C,
                           A_PEND_S = 6'h30, A_IEN_S  = 6'h34, A_MIRR_S = 6'h38,
                           A_SEL    = 6'h3C;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        priv_ok;
    logic        bus_we;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_dual_bank u0 (
        .clk(clk), .rst_n(rst_n), .priv_ok(priv_ok), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_out(input logic [31:0] sel, dc, ds);
        return (sel & dc) | (~sel & ds);
    endfunction

    function automatic logic [31:0] exp_oe(input logic [31:0] sel, rc, rs, en);
        return ((sel & rc) | (~sel & rs)) & en;
    endfunction

    function automatic logic [31:0] exp_flags(input logic [31:0] owned, pins, pol);
        return owned & ~(pins ^ pol);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, a_val, pins, prev;
        logic [31:0] sel, dc, ds, rc, rs, en, polc, pols, ienc, iens, ec, es;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; priv_ok = 1'b1; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0; pin_in = '0;
        repeat (3) @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(6'(a * 4), d);
            chk("R1 register reads zero in reset", d, 32'h0);
        end
        chk("R1 pin_oe in reset", pin_oe, 32'h0);
        chk("R1 pin_out in reset", pin_out, 32'h0);
        chk("R1 irq_out in reset", {31'h0, irq_out}, 32'h0);
        rst_n = 1'b1;
        idle(1);

        // R3: secure bank gating
        a_val = $urandom();
        wr(A_SEL, a_val);
        rd(A_SEL, d);           chk("R3 SEL readback permitted", d, a_val);
        priv_ok = 1'b0;
        wr(A_SEL, ~a_val);
        rd(A_SEL, d);           chk("R3 SEL hidden without permission", d, 32'h0);
        wr(A_EN, ONES);
        wr(A_DOUT_C, 32'h1234_5678);
        rd(A_DOUT_C, d);        chk("R3 common bank open without permission", d, 32'h1234_5678);
        priv_ok = 1'b1;
        rd(A_SEL, d);           chk("R3 SEL unchanged by denied write", d, a_val);
        rd(A_EN, d);            chk("R3 LINE_EN unchanged by denied write", d, 32'h0);

        // R2: misaligned address selects nothing
        rd(6'h01, d);           chk("R2 misaligned read", d, 32'h0);
        rd(A_DOUT_C | 6'h2, d); chk("R2 misaligned read 2", d, 32'h0);

        // R4 R5: owner routing of output and direction
        for (int i = 0; i < 24; i++) begin
            sel = $urandom(); dc = $urandom(); ds = $urandom();
            rc = $urandom(); rs = $urandom(); en = $urandom();
            if (i == 0) begin sel = ONES; en = ONES; end
            if (i == 1) begin sel = 32'h0; en = ONES; end
            wr(A_SEL, sel); wr(A_DOUT_C, dc); wr(A_DOUT_S, ds);
            wr(A_DDIR_C, rc); wr(A_DDIR_S, rs); wr(A_EN, en);
            chk("R4 pin_out follows owner", pin_out, exp_out(sel, dc, ds));
            chk("R5 pin_oe owner DDIR and LINE_EN", pin_oe, exp_oe(sel, rc, rs, en));
            rd(A_DOUT_S, d);    chk("R4 secure DOUT stored", d, ds);
            rd(A_DDIR_C, d);    chk("R4 common DDIR stored", d, rc);
        end

        // R6: synchronised input view and its latency
        prev = pin_in;
        for (int i = 0; i < 8; i++) begin
            pins = $urandom();
            pin_in = pins;
            rd(A_DIN_C, d);     chk("R6 DIN before any edge", d, prev);
            rd(A_DIN_C, d);     chk("R6 DIN after one edge", d, prev);
            rd(A_DIN_S, d);     chk("R6 secure DIN after two edges", d, pins);
            rd(A_MIRR_C, d);    chk("R6 common DIN_ALT", d, pins);
            rd(A_MIRR_S, d);    chk("R6 secure DIN_ALT", d, pins);
            wr(A_DIN_C, $urandom());
            rd(A_DIN_C, d);     chk("R6 DIN write ignored", d, pins);
            prev = pins;
        end

        // R7 R8 R9 R10: level detection per owner and polarity
        for (int i = 0; i < 16; i++) begin
            sel = $urandom(); polc = $urandom(); pols = $urandom();
            ienc = $urandom(); iens = $urandom(); pins = $urandom();
            if (i == 0) ienc = 32'h0;
            wr(A_SEL, sel); wr(A_POL_C, polc); wr(A_POL_S, pols);
            wr(A_IEN_C, ienc); wr(A_IEN_S, iens);
            pin_in = pins;
            idle(3);
            wr(A_PEND_C, ONES);
            rd(A_PEND_C, d);    chk("R8 common flags read zero after clear", d, 32'h0);
            wr(A_PEND_S, ONES);
            rd(A_PEND_S, d);    chk("R8 secure flags read zero after clear", d, 32'h0);
            ec = exp_flags(sel, pins, polc);
            es = exp_flags(~sel, pins, pols);
            rd(A_PEND_C, d);    chk("R7 R10 common flags re-set", d, ec);
            rd(A_PEND_S, d);    chk("R7 R10 secure flags re-set", d, es);
            chk("R9 irq_out from common flags", {31'h0, irq_out}, {31'h0, |(ec & ienc)});
        end

        // R7 R9: interrupt latency of a single line, active-high
        wr(A_SEL, ONES); wr(A_POL_C, ONES); wr(A_IEN_C, 32'h8);
        pin_in = 32'h0;
        idle(3);
        wr(A_PEND_C, ONES);
        idle(1);
        chk("R9 irq low with no source", {31'h0, irq_out}, 32'h0);
        pin_in = 32'h8;
        idle(1);                chk("R7 irq low after edge k", {31'h0, irq_out}, 32'h0);
        idle(1);                chk("R7 irq low after edge k+1", {31'h0, irq_out}, 32'h0);
        idle(1);                chk("R7 irq high after edge k+2", {31'h0, irq_out}, 32'h1);

        // R8: sticky flag, single-bit clear, stays clear
        pin_in = 32'h0;
        idle(3);
        rd(A_PEND_C, d);        chk("R8 flag sticky after level ends", d, 32'h8);
        wr(A_PEND_C, 32'h8);
        rd(A_PEND_C, d);        chk("R8 cleared flag", d, 32'h0);
        idle(2);
        rd(A_PEND_C, d);        chk("R8 flag stays clear", d, 32'h0);
        pin_in = 32'h30;
        idle(3);
        pin_in = 32'h0;
        idle(3);
        wr(A_PEND_C, 32'h10);
        rd(A_PEND_C, d);        chk("R8 only written bits clear", d, 32'h20);

        // R9: mask gating and secure flags excluded
        wr(A_IEN_C, 32'h20);
        chk("R9 irq with enabled flag", {31'h0, irq_out}, 32'h1);
        wr(A_IEN_C, 32'h0);
        chk("R9 irq masked by zero IEN", {31'h0, irq_out}, 32'h0);
        wr(A_SEL, 32'h0); wr(A_POL_S, 32'h0); wr(A_IEN_S, ONES); wr(A_IEN_C, ONES);
        wr(A_PEND_C, ONES);
        idle(3);
        rd(A_PEND_S, d);        chk("R10 secure flags for owned lines", d, ONES);
        rd(A_PEND_C, d);        chk("R10 common flags stay clear when not owner", d, 32'h0);
        chk("R9 secure flags do not raise irq", {31'h0, irq_out}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule